// File: doc/BRIEF.md
# Cascadable Presettable Modulo-16 Counter

This block is a four-bit synchronous binary counter. It steps through sixteen values and then wraps back to zero. A low level on the load input copies a parallel data word into the state on the next rising clock edge. Two count enables must both be high for the state to advance: a broadcast enable shared by a whole counter chain, and a chain enable that also qualifies the carry-out flag. The carry-out is combinational, so feeding each stage's carry-out into the next stage's chain enable builds a wide synchronous counter or a programmable divider with no extra clock latency between stages.

An active-low clear input forces the state to zero at once, with no clock edge needed. A small synchronizer times the release of that clear to the clock, so the first edge that can act after release is known in advance. On every clock edge the block performs exactly one operation: CLEAR while the synchronized reset is held, then LOAD, COUNT or HOLD by priority. The transitions are: LOAD whenever `load_n` is low; COUNT when load is inactive and both enables are high, going from 15 to 0 at the top; HOLD otherwise.

Top module: `presettable_ctr16`

## Requirements
- R1: With load inactive and both enables high, a state of 15 becomes 0 on the next rising clock edge.
- R2: While `clr_n` is low, `q` is 0 within the same clock period, with no clock edge needed, whatever `load_n`, `din` and the enables are.
- R3: While `load_n` is low and the block is out of reset, a rising edge copies `din` into `q`, whatever `en_par` and `en_chain` are.
- R4: With `load_n` high and both `en_par` and `en_chain` high, each rising edge increments `q` by one.
- R5: With `load_n` high and either `en_par` or `en_chain` low, a rising edge leaves `q` unchanged.
- R6: `carry_out` is high exactly when `en_chain` is high and `q` is 15, and it follows a change on `en_chain` with no clock edge.
- R7: `en_par` has no effect on `carry_out`.
- R8: After `clr_n` rises, the first SYNC_STAGES (default 2) rising edges leave `q` at 0. The next edge is the first one that loads or counts.
- R9: When stages are chained, with each `carry_out` driving the next stage's `en_chain` and one broadcast enable driving every `en_par` and the first `en_chain`, the stages together count as one wide binary counter that wraps at the top.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; active on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low; release is synchronized inside |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | WIDTH | Parallel data copied into the state on load |
| en_par | input | 1 | Broadcast count enable |
| en_chain | input | 1 | Chain count enable; also gates carry_out |
| q | output | WIDTH | Counter state |
| carry_out | output | 1 | Terminal count: en_chain AND state all ones |

## Verification
A wrong internal state shows on `q` one clock edge after the edge that corrupted it, because the state register drives the port directly. A decode fault such as a wrong load/count priority or a missing enable term also shows after one edge. A carry-out fault shows at once, without a clock, when the chain enable toggles while the state is 15. A synchronizer with the wrong depth moves the first count by a whole cycle. A fault in the carry path between chained stages only shows when the lower stages wrap, 16 or 256 edges after the corrupting edge.

// File: rtl/ctr16_pkg.sv
package ctr16_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } op_e;

endpackage

// File: rtl/ctr16_rst_sync.sv
module ctr16_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_q_n
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= '0;
                else         chain_q <= 1'b1;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= '0;
                else         chain_q <= {chain_q[TOP-1:0], 1'b1};
            end
        end
    endgenerate

    assign rst_q_n = chain_q[TOP];
endmodule

// File: rtl/ctr16_op_decode.sv
module ctr16_op_decode
    import ctr16_pkg::*;
(
    input  logic load_n,
    input  logic en_par,
    input  logic en_chain,
    output op_e  op
);
    always_comb begin
        unique casez ({load_n, en_par, en_chain})
            3'b0??:  op = OP_LOAD;
            3'b111:  op = OP_COUNT;
            3'b100,
            3'b101,
            3'b110:  op = OP_HOLD;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/ctr16_state_reg.sv
module ctr16_state_reg
    import ctr16_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] q_next;

    always_comb begin
        unique case (op)
            OP_LOAD:  q_next = din;
            OP_COUNT: q_next = q + ONE;
            OP_HOLD:  q_next = q;
            default:  q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end
endmodule

// File: rtl/ctr16_carry.sv
module ctr16_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_chain,
    output logic             carry_out
);
    always_comb begin
        carry_out = en_chain & (&q);
    end
endmodule

// File: rtl/presettable_ctr16.sv
module presettable_ctr16
    import ctr16_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par,
    input  logic             en_chain,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);
    logic rst_q_n;
    op_e  op;

    ctr16_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .arst_n  (clr_n),
        .rst_q_n (rst_q_n)
    );

    ctr16_op_decode u_dec (
        .load_n   (load_n),
        .en_par   (en_par),
        .en_chain (en_chain),
        .op       (op)
    );

    ctr16_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk   (clk),
        .rst_n (rst_q_n),
        .op    (op),
        .din   (din),
        .q     (q)
    );

    ctr16_carry #(.WIDTH(WIDTH)) u_carry (
        .q         (q),
        .en_chain  (en_chain),
        .carry_out (carry_out)
    );
endmodule

// File: rtl/ctr16_checker.sv
module ctr16_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             rst_q_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_par,
    input logic             en_chain,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);
    assert_clear_R2: assert property (@(posedge clk)
        !clr_n |-> (q == '0));

    assert_release_R8: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_n) |-> !rst_q_n);

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
        (load_n && en_par && en_chain && (&q)) |=> (q == '0));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
        !load_n |=> (q == $past(din)));

    assert_count_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
        (load_n && en_par && en_chain) |=> (q == WIDTH'($past(q) + 1'b1)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
        (load_n && !(en_par && en_chain)) |=> $stable(q));

    assert_carry_set_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
        (en_chain && (&q)) |-> carry_out);

    assert_carry_gate_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
        (!en_chain || !(&q)) |-> !carry_out);
endmodule

bind presettable_ctr16 ctr16_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .rst_q_n   (rst_q_n),
    .load_n    (load_n),
    .din       (din),
    .en_par    (en_par),
    .en_chain  (en_chain),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/sim_presettable_ctr16.sv
`timescale 1ns/1ps
module sim_presettable_ctr16;
    localparam int SYNC   = 2;
    localparam int NST    = 3;
    localparam int CW     = 4 * NST;
    localparam int CMOD   = 1 << CW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       clr_n    = 1'b1;
    logic       load_n   = 1'b1;
    logic [3:0] din      = '0;
    logic       en_par   = 1'b0;
    logic       en_chain = 1'b0;
    logic [3:0] q;
    logic       carry_out;

    presettable_ctr16 u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_chain(en_chain), .q(q), .carry_out(carry_out)
    );

    // chained divider: R9
    logic          ch_load_n = 1'b1;
    logic [CW-1:0] ch_din    = '0;
    logic          ch_en     = 1'b0;
    logic [CW-1:0] ch_q;
    logic [NST:0]  ch_cy;
    assign ch_cy[0] = ch_en;

    for (genvar k = 0; k < NST; k++) begin : g_chain
        presettable_ctr16 u_st (
            .clk(clk), .clr_n(clr_n), .load_n(ch_load_n),
            .din(ch_din[4*k +: 4]), .en_par(ch_en), .en_chain(ch_cy[k]),
            .q(ch_q[4*k +: 4]), .carry_out(ch_cy[k+1])
        );
    end

    int vectors = 0;
    int misses  = 0;
    int mq      = 0;
    int ch_ref  = 0;
    int rel     = 0;
    bit done    = 0;

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        if (!clr_n) begin
            mq = 0; ch_ref = 0; rel = 0;
        end else begin
            if (rel >= SYNC) begin
                if (!load_n) mq = din;
                else if (en_par && en_chain) mq = (mq + 1) % 16;
                if (!ch_load_n) ch_ref = ch_din;
                else if (ch_en) ch_ref = (ch_ref + 1) % CMOD;
            end
            if (rel < SYNC) rel++;
        end
        #1;
        check(tag, q, mq);
        check("R6", carry_out, (en_chain && mq == 15) ? 1 : 0);
        check("R9", ch_q, ch_ref);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        #1 clr_n = 1'b0;
        step("R2"); step("R2");
        check("R2", q, 0);

        // release: two edges held at zero, then counting (R8)
        load_n = 1'b1; en_par = 1'b1; en_chain = 1'b1;
        clr_n = 1'b1;
        step("R8"); check("R8", q, 0);
        step("R8"); check("R8", q, 0);
        step("R8"); check("R8", q, 1);

        // count through the wrap (R4, R1)
        for (int i = 0; i < 20; i++) step((mq == 15) ? "R1" : "R4");

        // hold with each enable low (R5)
        en_par = 1'b0;
        for (int i = 0; i < 3; i++) step("R5");
        en_par = 1'b1; en_chain = 1'b0;
        for (int i = 0; i < 3; i++) step("R5");

        // load beats enables (R3)
        load_n = 1'b0; din = 4'd9; en_par = 1'b0; en_chain = 1'b0;
        step("R3");
        din = 4'd15; en_par = 1'b1; en_chain = 1'b1;
        step("R3");

        // carry is combinational on en_chain, ignores en_par (R6, R7)
        load_n = 1'b1; en_chain = 1'b0;
        #1 check("R6", carry_out, 0);
        en_chain = 1'b1;
        #1 check("R6", carry_out, 1);
        en_par = 1'b0;
        #1 check("R7", carry_out, 1);
        en_par = 1'b1;
        #1 check("R7", carry_out, 1);
        en_chain = 1'b0;
        #1 check("R6", carry_out, 0);
        step("R5");

        // asynchronous clear mid-period overrides a load (R2)
        load_n = 1'b0; din = 4'd12;
        step("R3");
        #0.5 clr_n = 1'b0;
        mq = 0; ch_ref = 0; rel = 0;
        #0.5 check("R2", q, 0);
        step("R2"); step("R2");
        load_n = 1'b1; en_par = 1'b1; en_chain = 1'b1;
        clr_n = 1'b1;
        step("R8"); step("R8"); step("R8");
        check("R8", q, 1);

        // chained counter across the top wrap and nibble carries (R9)
        en_par = 1'b0;
        ch_load_n = 1'b0; ch_din = 12'hFFD;
        step("R9");
        ch_load_n = 1'b1; ch_en = 1'b1;
        for (int i = 0; i < 6; i++) step("R9");
        ch_en = 1'b0;
        step("R9");
        ch_load_n = 1'b0; ch_din = 12'h0FE;
        step("R9");
        ch_load_n = 1'b1; ch_en = 1'b1;
        for (int i = 0; i < 40; i++) step("R9");
        ch_load_n = 1'b0; ch_din = 12'h5EF;
        step("R9");
        ch_load_n = 1'b1;
        for (int i = 0; i < 300; i++) step("R9");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule